// File: doc/BRIEF.md
# Fast Ethernet Transmit Code-Group Encoder

This block sits on the transmit side of a 100 Mb/s physical coding sublayer. It takes one 4-bit nibble per clock from the media-independent interface, together with transmit enable and transmit error. For each nibble it produces one 5-bit code group. Between frames it sends idle code groups. At the start of a frame, the first two nibbles are replaced by the start-of-stream pair J/K. The rest of the preamble and all data nibbles go through the 4B/5B table. When transmit enable falls, the end-of-stream pair T/R is appended.

The output is registered. A code group appears one clock after the nibble it encodes, and a valid strobe marks every clock after reset. The scrambler, serializer and line coding that follow this block are not part of it.

Top module: `tx_cgroup_encoder`

## Requirements
- R1: While rstN is low, codeOut is 11111 and codeValid is 0. From the first rising clock edge with rstN high, codeValid is 1 on every clock.
- R2: Each code group is registered. It appears on codeOut one clock after the edge that sampled its nibble and control inputs.
- R3: While no frame is active and txEn is sampled low, codeOut is the idle group 11111.
- R4: The first nibble sampled with txEn high after idle produces J (11000). The second produces K (10001). The nibble values and txEr have no effect on these two groups.
- R5: Each later nibble sampled with txEn high and txEr low maps as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R6: A nibble after the K position sampled with txEn high and txEr high produces the error group H (00100) instead of its data group.
- R7: The first sample with txEn low after a frame produces T (01101). The next clock produces R (00111). Idle follows from the clock after that.
- R8: If txEn falls right after the J position, the sequence is J, T, R. No K is sent.
- R9: A sample with txEn high taken while R is being produced is discarded. R is still emitted. If txEn stays high, J comes on the next clock, so the new frame's J/K starts only after R completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEn | input | 1 | Transmit enable from the MAC side |
| txEr | input | 1 | Transmit error from the MAC side |
| txNibble | input | 4 | Transmit data nibble |
| codeOut | output | 5 | Encoded 5-bit code group |
| codeValid | output | 1 | High on every clock after reset with a code group on codeOut |

## Verification
The embedded assertions check the delimiter sequencing on every clock:
- J is always followed by K or T.
- T is always followed by R.
- R is always followed by idle or J.
- The valid strobe never drops after reset.

Only the bench scenarios can show the rest. These are:
- the table mapping for each data value;
- the substitution of H under txEr;
- the discarding of the first two nibbles;
- the loss of a nibble that arrives during R.

The bench covers them with random frames of random length, error and gap, plus directed short frames and back-to-back restarts.

// File: rtl/txcg_pkg.sv
package txcg_pkg;
  localparam int NibW  = 4;
  localparam int CodeW = 5;

  localparam logic [CodeW-1:0] CgIdle = 5'b11111;
  localparam logic [CodeW-1:0] CgJ    = 5'b11000;
  localparam logic [CodeW-1:0] CgK    = 5'b10001;
  localparam logic [CodeW-1:0] CgT    = 5'b01101;
  localparam logic [CodeW-1:0] CgR    = 5'b00111;
  localparam logic [CodeW-1:0] CgH    = 5'b00100;

  typedef enum logic [1:0] {
    StIdle = 2'd0,
    StK    = 2'd1,
    StData = 2'd2,
    StR    = 2'd3
  } ctlState_t;

  // Strobes from control to datapath: which group to load next
  typedef struct packed {
    logic emitJ;
    logic emitK;
    logic emitT;
    logic emitR;
    logic emitErr;
    logic emitData;
  } cgSel_t;
endpackage

// File: rtl/txcg_ctrl.sv
module txcg_ctrl
  import txcg_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   txEn,
  input  logic   txEr,
  output cgSel_t sel
);
  ctlState_t curSt, nxtSt;

  always_comb begin
    sel   = '0;
    nxtSt = curSt;
    unique case (curSt)
      StIdle: begin
        if (txEn) begin
          sel.emitJ = 1'b1;
          nxtSt     = StK;
        end
      end
      StK: begin
        if (txEn) begin
          sel.emitK = 1'b1;
          nxtSt     = StData;
        end else begin
          sel.emitT = 1'b1;
          nxtSt     = StR;
        end
      end
      StData: begin
        if (!txEn) begin
          sel.emitT = 1'b1;
          nxtSt     = StR;
        end else if (txEr) begin
          sel.emitErr = 1'b1;
        end else begin
          sel.emitData = 1'b1;
        end
      end
      StR: begin
        sel.emitR = 1'b1;
        nxtSt     = StIdle;
      end
      default: nxtSt = StIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) curSt <= StIdle;
    else       curSt <= nxtSt;
  end

  // R7: once R is chosen the machine returns to idle
  a_r7_r_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (curSt == StR) |=> (curSt == StIdle));

  // R4: the K position is reached only from idle
  a_r4_k_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    (curSt == StK) |-> ($past(curSt) == StIdle));
endmodule

// File: rtl/txcg_dpath.sv
module txcg_dpath
  import txcg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cgSel_t           sel,
  input  logic [NibW-1:0]  txNibble,
  output logic [CodeW-1:0] codeOut,
  output logic             codeValid
);
  function automatic logic [CodeW-1:0] mapNibble(input logic [NibW-1:0] n);
    logic [CodeW-1:0] c;
    unique case (n)
      4'h0: c = 5'b11110;  4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;  4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;  4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;  4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;  4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;  4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;  4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;  default: c = 5'b11101;
    endcase
    return c;
  endfunction

  logic [CodeW-1:0] nextCode;

  always_comb begin
    if      (sel.emitJ)    nextCode = CgJ;
    else if (sel.emitK)    nextCode = CgK;
    else if (sel.emitT)    nextCode = CgT;
    else if (sel.emitR)    nextCode = CgR;
    else if (sel.emitErr)  nextCode = CgH;
    else if (sel.emitData) nextCode = mapNibble(txNibble);
    else                   nextCode = CgIdle;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeOut   <= CgIdle;
      codeValid <= 1'b0;
    end else begin
      codeOut   <= nextCode;
      codeValid <= 1'b1;
    end
  end

  // R4/R8: J is followed by K, or by T for a one-nibble frame
  a_r4_j_then_k: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == CgJ) |=> (codeOut == CgK || codeOut == CgT));

  // R7: T is always followed by R
  a_r7_t_then_r: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == CgT) |=> (codeOut == CgR));

  // R9: after R only idle or a fresh J can appear
  a_r9_after_r: assert property (@(posedge clk) disable iff (!rstN)
    (codeOut == CgR) |=> (codeOut == CgIdle || codeOut == CgJ));

  // R1: valid stays up once out of reset
  a_r1_valid_held: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> codeValid);

  // R8: controls never select two groups at once
  a_r8_sel_single: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sel));
endmodule

// File: rtl/tx_cgroup_encoder.sv
module tx_cgroup_encoder
  import txcg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEn,
  input  logic             txEr,
  input  logic [NibW-1:0]  txNibble,
  output logic [CodeW-1:0] codeOut,
  output logic             codeValid
);
  cgSel_t sel;

  txcg_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .txEn (txEn),
    .txEr (txEr),
    .sel  (sel)
  );

  txcg_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .sel       (sel),
    .txNibble  (txNibble),
    .codeOut   (codeOut),
    .codeValid (codeValid)
  );
endmodule

// File: tb/sim_tx_cgroup_encoder.sv
module sim_tx_cgroup_encoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, txEn, txEr;
  logic [3:0] txNibble;
  logic [4:0] codeOut;
  logic       codeValid;

  int nCmp = 0;
  int nBad = 0;
  int mSt  = 0;   // 0 idle, 1 K next, 2 data, 3 R next
  bit done = 0;

  tx_cgroup_encoder u0 (
    .clk(clk), .rstN(rstN), .txEn(txEn), .txEr(txEr),
    .txNibble(txNibble), .codeOut(codeOut), .codeValid(codeValid)
  );

  // R5 table as given in the requirements
  function automatic logic [4:0] refData(input logic [3:0] n);
    logic [4:0] t [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                            5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
    return t[n];
  endfunction

  task automatic cmp(input string req, input logic [4:0] act, input logic [4:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic er, input logic [3:0] nib);
    logic [4:0] exp;
    string req;
    @(negedge clk);
    txEn = en; txEr = er; txNibble = nib;
    case (mSt)
      0: if (en) begin exp = 5'b11000; req = "R4"; mSt = 1; end
         else    begin exp = 5'b11111; req = "R3"; end
      1: if (en) begin exp = 5'b10001; req = "R4"; mSt = 2; end
         else    begin exp = 5'b01101; req = "R8"; mSt = 3; end
      2: if (!en)    begin exp = 5'b01101; req = "R7"; mSt = 3; end
         else if (er) begin exp = 5'b00100; req = "R6"; end
         else         begin exp = refData(nib); req = "R5"; end
      default: begin exp = 5'b00111; req = en ? "R9" : "R7"; mSt = 0; end
    endcase
    @(posedge clk);
    #1;
    cmp({req, " (R2 latency)"}, codeOut, exp);
    cmp("R1 valid", {4'b0, codeValid}, 5'd1);
  endtask

  task automatic frame(input int len, input int gap, input int errOdds);
    for (int i = 0; i < len; i++)
      step(1'b1, (errOdds > 0) && ($urandom_range(errOdds - 1) == 0), 4'($urandom));
    for (int i = 0; i < gap; i++)
      step(1'b0, 1'b0, 4'($urandom));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    rstN = 1'b0; txEn = 1'b1; txEr = 1'b1; txNibble = 4'h5;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 reset code", codeOut, 5'b11111);
    cmp("R1 reset valid", {4'b0, codeValid}, 5'd0);
    txEn = 1'b0; txEr = 1'b0;
    rstN = 1'b1;
    mSt  = 0;
    // R3 idle fill
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 4'hA);
    // R5 every data value in order
    step(1'b1, 1'b1, 4'h0);     // R4: error ignored at J
    step(1'b1, 1'b1, 4'h3);     // R4: error ignored at K
    for (int v = 0; v < 16; v++) step(1'b1, 1'b0, 4'(v));
    step(1'b1, 1'b1, 4'h7);     // R6 H substitution
    step(1'b0, 1'b0, 4'h0);     // R7 T
    step(1'b0, 1'b0, 4'h0);     // R7 R
    step(1'b0, 1'b0, 4'h0);     // R3 idle after R
    // R8 one-nibble frame: J T R
    frame(1, 3, 0);
    // R9 restart right after T: R kept, J next
    frame(4, 1, 0);
    frame(3, 2, 0);
    // random frames
    for (int f = 0; f < 300; f++)
      frame($urandom_range(1, 20), 1 + $urandom_range(0, 3), 16);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule